// File: doc/BRIEF.md
# Power-Fail Store and Power-Up Recall Sequencer

This controller sits beside a battery-free non-volatile SRAM and decides when the array must copy its contents into the non-volatile cells and when it must copy them back. It does not measure the supply itself. Two synchronized comparator flags tell it whether the supply is under the switch threshold and whether it is under the deeper reset threshold. From these flags it produces a store request, a recall request, an access-inhibit signal that blocks SRAM writes and externally requested stores, and a drive enable for the shared open-drain busy line.

When the supply falls, the controller drives the busy line low for a short probe window. It starts a store only if the SRAM was written since the last non-volatile cycle and the busy line was actually seen low. A store ends on a done handshake from the array or after a maximum store period. The controller then stays disabled until the busy line reads high again. A recall is armed only by a dip under the reset threshold, or by reset, and it runs for a fixed restore period once the supply is back above the switch threshold. All periods are parameters counted in clock cycles.

Top module: `nvs_powerfail_seq`

## Requirements
- R1: After reset the recall latch is set, `access_inhibit` is 1 and `store_req`, `recall_req` and `busy_drive` are 0. The first cycle in which `supply_below_switch` is seen low starts a recall.
- R2: `access_inhibit` is 1 whenever the supply is under the switch threshold or the controller is not in normal operation. A pulse on `sram_wr` while `access_inhibit` is 1 does not mark the SRAM as written.
- R3: With the automatic store enabled, a rising `supply_below_switch` drives `busy_drive` for exactly PULSE_CYC cycles. If no write occurred since the last store or recall, the line is then released and no store takes place.
- R4: If a write occurred and the busy pin was seen low during the probe window, `store_req` follows the probe window. `store_req` stays 1 until the cycle after `store_done` is sampled high, and never for more than STORE_CYC cycles. `busy_drive` stays 1 for the whole store.
- R5: If `busy_pin_in` stays high for the whole probe window, the store attempt is abandoned and no `store_req` is issued.
- R6: While `autostore_off` is 1, a supply fall never drives `busy_drive` and never issues `store_req`.
- R7: A cycle with `supply_below_reset` high sets the recall latch. When the supply later returns above the switch threshold, `recall_req` is 1 for exactly RESTORE_CYC cycles, starting one clock after `supply_below_switch` is sampled low. The controller then returns to normal operation. `store_req` and `recall_req` are never 1 together.
- R8: A brownout that never reaches the reset threshold does not produce `recall_req` when the supply comes back. `access_inhibit` drops one clock after `supply_below_switch` is sampled low.
- R9: After a store ends, `access_inhibit` stays 1 with `busy_drive` 0 for as long as `busy_pin_in` reads low, even if the supply has recovered.
- R10: `supply_below_reset` during a store or recall cancels the operation in the next cycle. The controller returns to its power-off state with the recall latch set.
- R11: A completed store or a completed recall clears the written-since-last-cycle flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_below_switch | input | 1 | Supply under the switch threshold (synchronized) |
| supply_below_reset | input | 1 | Supply under the reset threshold (synchronized) |
| autostore_off | input | 1 | 1 disables the automatic store on power loss |
| sram_wr | input | 1 | Pulse: an SRAM write was performed |
| busy_pin_in | input | 1 | Sensed level of the shared busy line (1 = high) |
| store_done | input | 1 | Array reports that the store has finished |
| store_req | output | 1 | Store SRAM contents into non-volatile cells |
| recall_req | output | 1 | Restore SRAM contents from non-volatile cells |
| access_inhibit | output | 1 | Blocks SRAM writes and external store requests |
| busy_drive | output | 1 | Pull the shared busy line low |

## Verification
The bound checker watches, on every cycle, that a store always comes with the busy line driven, that a store never outlasts its maximum period, and that store and recall requests are exclusive and inhibit access. It also checks that a recall starts only after a clean supply return and that a reset-level dip clears every request in the next cycle. Only the bench scenarios can show the durations of the probe, store and restore windows. The same holds for the write-tracking decisions that chain from one power cycle to the next, the abandoned store when the busy line is held high, and the hold-off while the busy line is pulled low after a store.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   typedef enum logic [2:0] {
      ST_LOW    = 3'd0,
      ST_RECALL = 3'd1,
      ST_RUN    = 3'd2,
      ST_PROBE  = 3'd3,
      ST_STORE  = 3'd4,
      ST_HOLD   = 3'd5
   } nvs_state_e;

   function automatic int unsigned nvs_max3(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/nvs_period_timer.sv
module nvs_period_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/nvs_flag_latch.sv
module nvs_flag_latch #(
   parameter bit SET_WINS  = 1'b1,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   logic d;

   generate
      if (SET_WINS) begin : g_set_priority
         always_comb begin
            if (set)      d = 1'b1;
            else if (clr) d = 1'b0;
            else          d = q;
         end
      end else begin : g_clr_priority
         always_comb begin
            if (clr)      d = 1'b0;
            else if (set) d = 1'b1;
            else          d = q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RESET_VAL;
      else        q <= d;
   end

endmodule

// File: rtl/nvs_powerfail_seq.sv
module nvs_powerfail_seq
   import nvs_pkg::*;
#(
   parameter int unsigned PULSE_CYC   = 250,
   parameter int unsigned RESTORE_CYC = 137500,
   parameter int unsigned STORE_CYC   = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_below_switch,
   input  logic supply_below_reset,
   input  logic autostore_off,
   input  logic sram_wr,
   input  logic busy_pin_in,
   input  logic store_done,
   output logic store_req,
   output logic recall_req,
   output logic access_inhibit,
   output logic busy_drive
);

   localparam int unsigned MAX_CYC = nvs_max3(PULSE_CYC, RESTORE_CYC, STORE_CYC);
   localparam int unsigned CW      = $clog2(MAX_CYC + 1);

   generate
      if (PULSE_CYC < 1)   begin : g_bad_pulse   $error("PULSE_CYC must be at least 1");   end
      if (RESTORE_CYC < 1) begin : g_bad_restore $error("RESTORE_CYC must be at least 1"); end
      if (STORE_CYC < 1)   begin : g_bad_store   $error("STORE_CYC must be at least 1");   end
   endgenerate

   nvs_state_e    state_q, state_n;
   logic          tmr_zero;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          dirty_q;
   logic          recall_pend_q;
   logic          pin_seen_q;
   logic          pin_seen_now;
   logic          store_fin;
   logic          recall_fin;
   logic          dirty_set;
   logic          seen_set;
   logic          seen_clr;

   assign pin_seen_now = pin_seen_q | ~busy_pin_in;

   // next-state selection; the reset-level flag overrides everything
   always_comb begin
      state_n = state_q;
      if (supply_below_reset) begin
         state_n = ST_LOW;
      end else begin
         case (state_q)
            ST_LOW: begin
               if (!supply_below_switch)
                  state_n = recall_pend_q ? ST_RECALL : ST_RUN;
            end
            ST_RECALL: begin
               if (supply_below_switch) state_n = ST_LOW;
               else if (tmr_zero)       state_n = ST_RUN;
            end
            ST_RUN: begin
               if (supply_below_switch)
                  state_n = autostore_off ? ST_LOW : ST_PROBE;
            end
            ST_PROBE: begin
               if (tmr_zero)
                  state_n = (pin_seen_now && dirty_q) ? ST_STORE : ST_LOW;
            end
            ST_STORE: begin
               if (store_done || tmr_zero) state_n = ST_HOLD;
            end
            ST_HOLD: begin
               if (busy_pin_in)
                  state_n = supply_below_switch ? ST_LOW : ST_RUN;
            end
            default: state_n = ST_LOW;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_LOW;
      else        state_q <= state_n;
   end

   // window timer reloaded on every state change
   always_comb begin
      tmr_load = (state_n != state_q);
      case (state_n)
         ST_PROBE:  tmr_val = CW'(PULSE_CYC - 1);
         ST_RECALL: tmr_val = CW'(RESTORE_CYC - 1);
         ST_STORE:  tmr_val = CW'(STORE_CYC - 1);
         default:   tmr_val = '0;
      endcase
   end

   nvs_period_timer #(.CW(CW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   assign store_fin  = (state_q == ST_STORE) && (store_done || tmr_zero) && !supply_below_reset;
   assign recall_fin = (state_q == ST_RECALL) && tmr_zero && !supply_below_switch
                       && !supply_below_reset;
   assign dirty_set  = sram_wr && (state_q == ST_RUN) && !supply_below_switch;
   assign seen_set   = (state_q == ST_PROBE) && !busy_pin_in;
   assign seen_clr   = (state_q != ST_PROBE);

   // written since the last non-volatile cycle
   nvs_flag_latch #(.SET_WINS(1'b0), .RESET_VAL(1'b0)) i_dirty (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (dirty_set),
      .clr   (store_fin | recall_fin),
      .q     (dirty_q)
   );

   // recall request armed by reset or a reset-level dip
   nvs_flag_latch #(.SET_WINS(1'b1), .RESET_VAL(1'b1)) i_recall_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (supply_below_reset),
      .clr   (recall_fin),
      .q     (recall_pend_q)
   );

   // busy line observed low during the probe window
   nvs_flag_latch #(.SET_WINS(1'b0), .RESET_VAL(1'b0)) i_pin_seen (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (seen_set),
      .clr   (seen_clr),
      .q     (pin_seen_q)
   );

   assign store_req      = (state_q == ST_STORE);
   assign recall_req     = (state_q == ST_RECALL);
   assign busy_drive     = (state_q == ST_PROBE) || (state_q == ST_STORE);
   assign access_inhibit = supply_below_switch || (state_q != ST_RUN);

endmodule

// File: rtl/nvs_powerfail_chk.sv
module nvs_powerfail_chk #(
   parameter int unsigned STORE_CYC = 2500000
) (
   input logic clk,
   input logic rst_n,
   input logic supply_below_switch,
   input logic supply_below_reset,
   input logic autostore_off,
   input logic store_req,
   input logic recall_req,
   input logic access_inhibit,
   input logic busy_drive
);

   localparam int unsigned LW = $clog2(STORE_CYC + 1);

   logic [LW-1:0] st_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         st_len_q <= '0;
      else if (store_req) st_len_q <= st_len_q + 1'b1;
      else                st_len_q <= '0;
   end

   assert_store_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> busy_drive);

   assert_store_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> (st_len_q < LW'(STORE_CYC)));

   assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(store_req && recall_req));

   assert_req_inhibits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req || recall_req) |-> access_inhibit);

   assert_probe_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_drive) |-> $past(!autostore_off));

   assert_recall_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recall_req) |-> $past(!supply_below_switch && !supply_below_reset));

   assert_dip_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
      supply_below_reset |=> (!store_req && !recall_req && !busy_drive));

endmodule

bind nvs_powerfail_seq nvs_powerfail_chk #(.STORE_CYC(STORE_CYC)) i_chk (
   .clk                 (clk),
   .rst_n               (rst_n),
   .supply_below_switch (supply_below_switch),
   .supply_below_reset  (supply_below_reset),
   .autostore_off       (autostore_off),
   .store_req           (store_req),
   .recall_req          (recall_req),
   .access_inhibit      (access_inhibit),
   .busy_drive          (busy_drive)
);

// File: tb/test_nvs_powerfail_seq.sv
`timescale 1ns/1ps
module test_nvs_powerfail_seq;

   localparam int P  = 6;
   localparam int RS = 40;
   localparam int SC = 30;
   localparam int DONE_AT = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic below_sw = 1'b1;
   logic below_rst = 1'b1;
   logic as_off = 1'b0;
   logic wr = 1'b0;
   logic store_done = 1'b0;
   logic store_req, recall_req, inhibit, busy_drive;
   logic pin_held = 1'b0;
   logic ext_low = 1'b0;
   logic done_en = 1'b1;
   logic pin;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int c_busy = 0, c_store = 0, c_recall = 0;
   int st_k = 0;
   bit exp_dirty = 1'b0;

   always #2 clk = ~clk;

   assign pin = pin_held ? 1'b1 : (ext_low ? 1'b0 : ~busy_drive);

   nvs_powerfail_seq #(.PULSE_CYC(P), .RESTORE_CYC(RS), .STORE_CYC(SC)) i_nvs_powerfail_seq (
      .clk                 (clk),
      .rst_n               (rst_n),
      .supply_below_switch (below_sw),
      .supply_below_reset  (below_rst),
      .autostore_off       (as_off),
      .sram_wr             (wr),
      .busy_pin_in         (pin),
      .store_done          (store_done),
      .store_req           (store_req),
      .recall_req          (recall_req),
      .access_inhibit      (inhibit),
      .busy_drive          (busy_drive)
   );

   // per-cycle monitor, sampled just after the edge; also models the array
   always @(posedge clk) begin
      #1;
      cyc++;
      if (busy_drive) c_busy++;
      if (store_req)  c_store++;
      if (recall_req) c_recall++;
      if (store_req) begin
         st_k++;
         store_done = done_en && (st_k == DONE_AT);
      end else begin
         st_k = 0;
         store_done = 1'b0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_cnt();
      c_busy = 0; c_store = 0; c_recall = 0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      wait (cyc > 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1: reset state
      chk("R1 inhibit", inhibit, 1);
      chk("R1 store_req", store_req, 0);
      chk("R1 recall_req", recall_req, 0);
      chk("R1 busy_drive", busy_drive, 0);
      below_rst = 1'b0;
      tick(2);
      clr_cnt();
      below_sw = 1'b0;
      tick(1);
      chk("R1 recall starts", recall_req, 1);
      tick(RS + 5);
      chk("R1 R7 recall length", c_recall, RS);
      chk("R7 back to run", inhibit, 0);

      // sweep: dirty, inhibit mode, pin held, reset dip, store timeout
      for (int c = 0; c < 32; c++) begin
         automatic bit do_wr = c[0];
         automatic bit inh   = c[1];
         automatic bit held  = c[2];
         automatic bit dip   = c[3];
         automatic bit tmo   = c[4];
         automatic int eb, es, sl;
         as_off = inh; pin_held = held; done_en = ~tmo;
         tick(1);
         if (do_wr) begin
            wr = 1'b1; tick(1); wr = 1'b0;
            exp_dirty = 1'b1;
         end
         tick(1);
         clr_cnt();
         below_sw = 1'b1;
         tick(1);
         chk("R2 inhibit on fall", inhibit, 1);
         tick(3);
         wr = 1'b1; tick(1); wr = 1'b0;   // R2: write while inhibited is ignored
         tick(60);
         sl = tmo ? SC : DONE_AT;
         if (inh) begin
            eb = 0; es = 0;                       // R6
         end else if (held) begin
            eb = P; es = 0;                       // R5
         end else if (exp_dirty) begin
            eb = P + sl; es = sl; exp_dirty = 1'b0;  // R4 R11
         end else begin
            eb = P; es = 0;                       // R3
         end
         chk(inh ? "R6 busy cycles" : (held ? "R5 busy cycles" : "R3 R4 busy cycles"), c_busy, eb);
         chk(inh ? "R6 store cycles" : (held ? "R5 store cycles" : "R4 store cycles"), c_store, es);
         pin_held = 1'b0;
         if (dip) begin
            below_rst = 1'b1; tick(3); below_rst = 1'b0;
         end
         tick(2);
         clr_cnt();
         below_sw = 1'b0;
         tick(1);
         chk(dip ? "R7 recall start" : "R8 no recall start", recall_req, dip);
         if (!dip) chk("R8 inhibit drops", inhibit, 0);
         tick(RS + 8);
         chk(dip ? "R7 recall length" : "R8 recall length", c_recall, dip ? RS : 0);
         if (dip) exp_dirty = 1'b0;   // R11
         chk("R7 R8 running", inhibit, 0);
      end

      // R10: reset-level dip during a store
      as_off = 1'b0; done_en = 1'b0;
      wr = 1'b1; tick(1); wr = 1'b0;
      below_sw = 1'b1;
      tick(P + 3);
      chk("R10 store active", store_req, 1);
      below_rst = 1'b1;
      tick(1);
      chk("R10 store cancelled", store_req, 0);
      chk("R10 busy released", busy_drive, 0);
      tick(2);
      below_rst = 1'b0;
      tick(2);
      clr_cnt();
      below_sw = 1'b0;
      tick(RS + 6);
      chk("R10 recall after cancel", c_recall, RS);
      done_en = 1'b1;

      // R11 check: recall cleared dirty, so the next fall stores nothing
      clr_cnt();
      below_sw = 1'b1;
      tick(40);
      chk("R11 no store when clean", c_store, 0);
      below_sw = 1'b0;
      tick(3);
      chk("R8 up again", inhibit, 0);

      // R9: busy line held low externally after a store
      wr = 1'b1; tick(1); wr = 1'b0;
      below_sw = 1'b1;
      tick(P + 3);
      chk("R9 store active", store_req, 1);
      ext_low = 1'b1;
      below_sw = 1'b0;
      tick(DONE_AT + 10);
      chk("R9 store ended", store_req, 0);
      chk("R9 still inhibited", inhibit, 1);
      chk("R9 busy not driven", busy_drive, 0);
      ext_low = 1'b0;
      tick(1);
      chk("R9 released", inhibit, 0);

      finish_run();
   end

endmodule